// File: doc/BRIEF.md
# NAND Page Hamming Code Generator

This block sits beside the data port of a NAND flash controller. It watches the bytes that cross the port and builds a single-error-correcting Hamming code over them. Each 256-byte chunk of a page gets its own 3-byte code. A page is one chunk (256 bytes) or two chunks (512 bytes), chosen by `big_page`. A 2-bit mode input steers the engine: clear, accumulate, read out, or idle. Software later uses the codes to correct errors. That correction step is outside this block.

Data bytes arrive on a valid/ready stream. `dat_ready` is high in every mode except read-out. A byte counts only when `dat_valid` and `dat_ready` are both high at a rising clock edge. The codes leave on a second valid/ready stream. `code_valid` is high while read-out mode is selected and code bytes remain. While `code_valid` is high and `code_ready` is low, `code_byte` holds its value. A byte is consumed at each edge where both are high.

A typical page write runs clear, then idle, then accumulate, then the data transfer. A code fetch runs idle, then read-out, then the code reads, then idle.

Top module: `nandecc_engine`

## Requirements
- R1: Mode 2'b11 clears the code state for every chunk and restarts accumulation at byte 0 of chunk 0. A read-out after a clear gives 0xFF for every code byte.
- R2: In mode 2'b01, each accepted byte updates the code of the current chunk. A byte is accepted when `dat_valid` and `dat_ready` are both high. Cycles with `dat_valid` low have no effect.
- R3: In mode 2'b00 and mode 2'b10, bytes presented on the data stream leave all codes unchanged.
- R4: The code layout for a chunk is defined as follows.
  - The byte parity of a data byte is the XOR of its 8 bits.
  - For chunk byte index i (0..255) and index bit k, line parity L(2k+1) is the XOR of the byte parities of the bytes with bit k of i set. L(2k) is the same XOR over the bytes with bit k clear.
  - Let X be the XOR of all bytes in the chunk. The column parities are:
    - C0 = X0^X2^X4^X6
    - C1 = X1^X3^X5^X7
    - C2 = X0^X1^X4^X5
    - C3 = X2^X3^X6^X7
    - C4 = X0^X1^X2^X3
    - C5 = X4^X5^X6^X7
  - Code byte 0 is ~L7..L0, with L0 in bit 0.
  - Code byte 1 is ~L15..L8.
  - Code byte 2 is {~C5,~C4,~C3,~C2,~C1,~C0,1,1}.
- R5: In read-out, each chunk's code is delivered in the order code byte 1, code byte 0, code byte 2. Chunk 0 comes first.
- R6: With `big_page`=1, accepted bytes 0..255 feed chunk 0 and bytes 256..511 feed chunk 1. The two codes are independent, and read-out delivers 6 bytes.
- R7: With `big_page`=0, read-out delivers 3 bytes. Accepted bytes beyond the page capacity (256 or 512) are ignored.
- R8: The read-out position returns to the first byte of chunk 0 each time the mode enters 2'b10.
- R9: While `code_valid` is high and `code_ready` is low, `code_byte` stays stable. After the last code byte is consumed, `code_valid` stays low until read-out mode is re-entered.
- R10: `dat_ready` is low in mode 2'b10 and high in every other mode.
- R11: A page in which every byte is 0xFF yields 0xFF for every code byte.
- R12: After reset, `code_valid` is low. The codes read as though a clear had been done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_mode | input | 2 | 11 clear, 01 accumulate, 10 read out, 00 idle |
| big_page | input | 1 | 1: two 256-byte chunks per page; 0: one chunk |
| dat_valid | input | 1 | Data byte present on the port |
| dat_ready | output | 1 | Engine accepts data bytes |
| dat_byte | input | 8 | Data byte crossing the NAND port |
| code_valid | output | 1 | A code byte is available |
| code_ready | input | 1 | Consumer takes the code byte |
| code_byte | output | 8 | Code byte in permuted order |

## Verification
Several behaviours are checked on every cycle:
- the byte position and chunk index hold still in the idle and read-out modes;
- a clear zeroes them;
- a byte with even bit parity leaves the line parity alone;
- read-out always starts at chunk 0 on entry;
- a stalled code byte holds still.

Other behaviours only the bench's scenarios can show. These are the code values themselves for different data patterns, the 1-0-2 order, the split between two chunks, dropping bytes beyond the page capacity, and the all-0xFF case. The bench checks them against codes computed from the line and column parity definitions.

// File: rtl/nandecc_pkg.sv
package nandecc_pkg;

  typedef enum logic [1:0] {
    ECC_OFF  = 2'b00,
    ECC_ACC  = 2'b01,
    ECC_READ = 2'b10,
    ECC_CLR  = 2'b11
  } ecc_mode_e;

  localparam int CHUNK_BYTES = 256;
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam int LP_W        = 2 * IDX_W;
  localparam int CODE_W      = 24;

  typedef struct packed {
    logic [LP_W-1:0] lp;    // line parity accumulators
    logic [7:0]      colx;  // running XOR of all bytes
  } chunk_acc_t;

  // Forms {byte2, byte1, byte0} from the raw accumulators.
  function automatic logic [CODE_W-1:0] form_code(chunk_acc_t a);
    logic [5:0] cp;
    cp[0] = a.colx[0] ^ a.colx[2] ^ a.colx[4] ^ a.colx[6];
    cp[1] = a.colx[1] ^ a.colx[3] ^ a.colx[5] ^ a.colx[7];
    cp[2] = a.colx[0] ^ a.colx[1] ^ a.colx[4] ^ a.colx[5];
    cp[3] = a.colx[2] ^ a.colx[3] ^ a.colx[6] ^ a.colx[7];
    cp[4] = ^a.colx[3:0];
    cp[5] = ^a.colx[7:4];
    return {~cp, 2'b11, ~a.lp[15:8], ~a.lp[7:0]};
  endfunction

endpackage

// File: rtl/nandecc_tracker.sv
module nandecc_tracker
  import nandecc_pkg::*;
#(
  parameter int CHUNKS_MAX = 2,
  localparam int CH_W = (CHUNKS_MAX > 1) ? $clog2(CHUNKS_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ecc_mode_e        mode,
  input  logic             big_page,
  input  logic             take,
  output logic [IDX_W-1:0] byte_idx,
  output logic [CH_W-1:0]  chunk_sel,
  output logic             upd,
  output logic             clr
);

  logic            full;
  logic [CH_W-1:0] last_chunk;

  assign last_chunk = big_page ? CH_W'(CHUNKS_MAX - 1) : '0;
  assign clr        = (mode == ECC_CLR);
  assign upd        = take && (mode == ECC_ACC) && !full;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      byte_idx  <= '0;
      chunk_sel <= '0;
      full      <= 1'b0;
    end else if (upd) begin
      byte_idx <= byte_idx + 1'b1;
      if (&byte_idx) begin
        if (chunk_sel == last_chunk) full <= 1'b1;
        else chunk_sel <= chunk_sel + 1'b1;
      end
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ECC_OFF || mode == ECC_READ) |=> $stable(byte_idx) && $stable(chunk_sel));

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ECC_CLR) |=> (byte_idx == '0) && (chunk_sel == '0));

  // R7
  chunk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !big_page |-> (chunk_sel == '0));

endmodule

// File: rtl/nandecc_chunk_acc.sv
module nandecc_chunk_acc
  import nandecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       dat_byte,
  output chunk_acc_t       acc
);

  logic            bpar;
  logic [LP_W-1:0] lp_flip;

  assign bpar = ^dat_byte;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lp_flip[2*k+1] = bpar &  byte_idx[k];
    assign lp_flip[2*k]   = bpar & ~byte_idx[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc <= '0;
    end else if (upd) begin
      acc.lp   <= acc.lp ^ lp_flip;
      acc.colx <= acc.colx ^ dat_byte;
    end
  end

  // R2
  even_byte_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && !(^dat_byte)) |=> $stable(acc.lp));

  // R2
  no_update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(acc));

endmodule

// File: rtl/nandecc_readout.sv
module nandecc_readout
  import nandecc_pkg::*;
#(
  parameter int CHUNKS_MAX = 2,
  localparam int CH_W = (CHUNKS_MAX > 1) ? $clog2(CHUNKS_MAX) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  ecc_mode_e                          mode,
  input  logic                               big_page,
  input  logic [CHUNKS_MAX-1:0][CODE_W-1:0]  codes,
  output logic                               code_valid,
  input  logic                               code_ready,
  output logic [7:0]                         code_byte
);

  logic [CH_W-1:0]   rd_chunk;
  logic [1:0]        rd_slot;
  logic              done;
  logic [CH_W-1:0]   last_chunk;
  logic [CODE_W-1:0] sel;

  assign last_chunk = big_page ? CH_W'(CHUNKS_MAX - 1) : '0;
  assign code_valid = (mode == ECC_READ) && !done;
  assign sel        = codes[rd_chunk];

  always_comb begin
    unique case (rd_slot)
      2'd0:    code_byte = sel[15:8];
      2'd1:    code_byte = sel[7:0];
      default: code_byte = sel[23:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode != ECC_READ) begin
      rd_chunk <= '0;
      rd_slot  <= '0;
      done     <= 1'b0;
    end else if (code_valid && code_ready) begin
      if (rd_slot == 2'd2) begin
        rd_slot <= '0;
        if (rd_chunk == last_chunk) done <= 1'b1;
        else rd_chunk <= rd_chunk + 1'b1;
      end else begin
        rd_slot <= rd_slot + 1'b1;
      end
    end
  end

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ECC_READ && $past(mode) != ECC_READ) |-> (rd_chunk == '0 && rd_slot == '0 && !done));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready) |=> (mode != ECC_READ) || $stable(code_byte));

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot != 2'd3);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !code_valid || $past(mode) != ECC_READ || mode != ECC_READ || done);

endmodule

// File: rtl/nandecc_engine.sv
module nandecc_engine
  import nandecc_pkg::*;
#(
  parameter int CHUNKS_MAX = 2,
  localparam int CH_W = (CHUNKS_MAX > 1) ? $clog2(CHUNKS_MAX) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ecc_mode,
  input  logic       big_page,
  input  logic       dat_valid,
  output logic       dat_ready,
  input  logic [7:0] dat_byte,
  output logic       code_valid,
  input  logic       code_ready,
  output logic [7:0] code_byte
);

  ecc_mode_e                       mode;
  logic                            take;
  logic [IDX_W-1:0]                byte_idx;
  logic [CH_W-1:0]                 chunk_sel;
  logic                            upd;
  logic                            clr;
  chunk_acc_t                      accs [CHUNKS_MAX];
  logic [CHUNKS_MAX-1:0][CODE_W-1:0] codes;

  assign mode      = ecc_mode_e'(ecc_mode);
  assign dat_ready = (mode != ECC_READ);
  assign take      = dat_valid && dat_ready;

  nandecc_tracker #(.CHUNKS_MAX(CHUNKS_MAX)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .big_page  (big_page),
    .take      (take),
    .byte_idx  (byte_idx),
    .chunk_sel (chunk_sel),
    .upd       (upd),
    .clr       (clr)
  );

  for (genvar c = 0; c < CHUNKS_MAX; c++) begin : g_chunk
    logic upd_c;
    assign upd_c = upd && (chunk_sel == CH_W'(c));

    nandecc_chunk_acc u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .upd      (upd_c),
      .byte_idx (byte_idx),
      .dat_byte (dat_byte),
      .acc      (accs[c])
    );

    assign codes[c] = form_code(accs[c]);
  end

  nandecc_readout #(.CHUNKS_MAX(CHUNKS_MAX)) u_readout (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .big_page   (big_page),
    .codes      (codes),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_byte  (code_byte)
  );

  // R10
  port_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_ready && code_valid));

endmodule

// File: tb/nandecc_engine_bench.sv
module nandecc_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ecc_mode = 2'b00;
  logic       big_page = 1'b0;
  logic       dat_valid = 1'b0;
  logic       dat_ready;
  logic [7:0] dat_byte = 8'h00;
  logic       code_valid;
  logic       code_ready = 1'b0;
  logic [7:0] code_byte;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] pg [512];

  logic       stalled = 1'b0;
  logic [7:0] held = 8'h00;

  always #2.5 clk = ~clk;

  nandecc_engine u_nandecc_engine (
    .clk(clk), .rst_n(rst_n), .ecc_mode(ecc_mode), .big_page(big_page),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .code_valid(code_valid), .code_ready(code_ready), .code_byte(code_byte)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: scoreboard pop and stall-hold comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled && code_valid && ecc_mode == 2'b10)
        check("R9 hold", code_byte, held);
      stalled = code_valid && !code_ready;
      held    = code_byte;
      if (code_valid && code_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 extra byte", code_byte, 8'hxx);
        end else begin
          string t;
          logic [7:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, code_byte, e);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [23:0] ref_code(int base);
    logic [15:0] lp = '0;
    logic [7:0]  x  = '0;
    logic [5:0]  cp;
    for (int i = 0; i < 256; i++) begin
      logic p;
      p = ^pg[base + i];
      x = x ^ pg[base + i];
      for (int k = 0; k < 8; k++) begin
        if (i[k]) lp[2*k+1] = lp[2*k+1] ^ p;
        else      lp[2*k]   = lp[2*k]   ^ p;
      end
    end
    cp[0] = x[0]^x[2]^x[4]^x[6];
    cp[1] = x[1]^x[3]^x[5]^x[7];
    cp[2] = x[0]^x[1]^x[4]^x[5];
    cp[3] = x[2]^x[3]^x[6]^x[7];
    cp[4] = ^x[3:0];
    cp[5] = ^x[7:4];
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction

  // Driver: pushes the expected code of a chunk in delivery order 1,0,2 (R5)
  task automatic push_chunk(int base, string tag);
    logic [23:0] c;
    c = ref_code(base);
    exp_q.push_back(c[15:8]);  tag_q.push_back({tag, " byte1"});
    exp_q.push_back(c[7:0]);   tag_q.push_back({tag, " byte0"});
    exp_q.push_back(c[23:16]); tag_q.push_back({tag, " byte2"});
  endtask

  task automatic push_ff(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(8'hFF);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain(bit bp, bit check_end);
    int n = 0;
    ecc_mode = 2'b10;
    while (exp_q.size() > 0) begin
      code_ready = bp ? (n % 3 != 0) : 1'b1;
      n++;
      step();
    end
    code_ready = 1'b1;
    if (check_end) begin
      @(negedge clk);
      check("R9 valid low after last", {7'd0, code_valid}, 8'h00);
      step();
    end
    code_ready = 1'b0;
    ecc_mode   = 2'b00;
    step();
  endtask

  task automatic send(logic [1:0] m, logic [7:0] b);
    ecc_mode  = m;
    dat_valid = 1'b1;
    dat_byte  = b;
    step();
    dat_valid = 1'b0;
  endtask

  task automatic clear_seq();
    ecc_mode = 2'b11; step();
    ecc_mode = 2'b00; step();
  endtask

  initial begin
    repeat (3) step();
    @(negedge clk);
    check("R12 code_valid at reset", {7'd0, code_valid}, 8'h00);
    check("R10 dat_ready idle", {7'd0, dat_ready}, 8'h01);
    rst_n = 1'b1;
    step();

    // R12: codes empty after reset
    push_ff(3, "R12 reset code");
    drain(1'b0, 1'b1);

    // R2 R3 R4 R5 R7: one chunk, idle bytes interleaved, gaps, overflow bytes
    big_page = 1'b0;
    clear_seq();
    for (int i = 0; i < 256; i++) pg[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 256; i++) begin
      if (i % 5 == 0) send(2'b00, 8'hA5);      // R3 ignored while idle
      if (i % 9 == 0) begin ecc_mode = 2'b01; step(); end  // valid low gap (R2)
      send(2'b01, pg[i]);
    end
    for (int i = 0; i < 10; i++) send(2'b01, 8'(i + 1)); // R7 beyond capacity
    ecc_mode = 2'b00; step();
    push_chunk(0, "R4 R5 chunk0");
    drain(1'b0, 1'b1);

    // R10 and R3: bytes offered during read-out are not taken
    ecc_mode = 2'b10;
    dat_valid = 1'b1; dat_byte = 8'h01;
    @(negedge clk);
    check("R10 dat_ready in readout", {7'd0, dat_ready}, 8'h00);
    repeat (4) step();
    dat_valid = 1'b0;
    ecc_mode = 2'b00; step();

    // R8: partial read, leave, re-enter from the start
    begin
      logic [23:0] c;
      c = ref_code(0);
      exp_q.push_back(c[15:8]); tag_q.push_back("R8 partial byte1");
      exp_q.push_back(c[7:0]);  tag_q.push_back("R8 partial byte0");
      drain(1'b0, 1'b0);
    end
    push_chunk(0, "R3 R8 restart");
    drain(1'b1, 1'b1);

    // R6 R9: two chunks, back-pressure
    big_page = 1'b1;
    clear_seq();
    for (int i = 0; i < 512; i++) pg[i] = 8'((i * 13) ^ (i >> 2));
    pg[300] = pg[300] ^ 8'h10;
    for (int i = 0; i < 512; i++) send(2'b01, pg[i]);
    send(2'b01, 8'h7E);  // R7 beyond 512
    ecc_mode = 2'b00; step();
    push_chunk(0,   "R6 chunk0");
    push_chunk(256, "R6 chunk1");
    drain(1'b1, 1'b1);

    // R1: clear wipes both chunks
    clear_seq();
    push_ff(6, "R1 cleared");
    drain(1'b0, 1'b1);

    // R11: all-0xFF page
    for (int i = 0; i < 512; i++) send(2'b01, 8'hFF);
    ecc_mode = 2'b00; step();
    push_ff(6, "R11 all FF");
    drain(1'b1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule